// File: doc/BRIEF.md
# Programmable Interval Clock

This block is a bus-addressed interval timer built around a 16-bit counter that moves up or down by one step on each tick of a selected time base. It has four time bases. Three are divided down from the system clock by a chain of prescalers, which run nominally at 100 kHz, 10 kHz and 10 Hz. The fourth is the synchronized rising edge of an external line-frequency input, nominally 60 Hz. Every time base reaches the counter as a one-cycle enable pulse, so the whole block runs in the system clock domain.

Software reaches three registers through a 2-bit register index. The control register holds run, rate, direction, repeat and interrupt-enable, plus the two read-only flags DONE and ERR. The set register holds the reload value. The counter register is read-only and returns the live count. When a step lands on zero, the block raises DONE. If DONE was still set from an earlier zero, it raises ERR instead. If interrupts are enabled, it also raises a level interrupt. In repeat mode the counter then reloads from the set register and keeps running. In single mode the set register is cleared and the clock stops. While the clock is stopped, software can advance the counter one step by writing the control register with the step bit set.

Top module: `interval_timer`

## Requirements
- R1: The register index is `addr_i[2:1]`. Index 0 is the control register, index 1 is the set register and index 2 is the counter. Index 3 reads as 0. Writes to index 2 or 3 change nothing.
- R2: Control register layout: bit0 RUN, bits[2:1] RATE, bit3 REPEAT, bit4 UP, bit5 STEP, bit6 IE, bit7 DONE, bit15 ERR. All other bits read 0. STEP always reads 0. DONE and ERR cannot be changed by a control write.
- R3: RATE selects the time base: 0 is the fast prescaler, 1 the medium prescaler, 2 the synchronized rising edge of `line_clk_i`, 3 the slow prescaler. While RUN is 1, each pulse of the selected base moves the counter one step. Pulses from the other bases have no effect.
- R4: UP=1 makes each step add 1 and UP=0 makes each step subtract 1. The count wraps modulo 2^16.
- R5: When a step gives zero, DONE is set. If DONE was already 1, ERR is set instead. If IE is 1 after the step, `irq_o` rises on the same edge.
- R6: On a zero with REPEAT=1, the counter reloads from the set register and RUN stays 1. On a zero with REPEAT=0, the set register becomes 0 and RUN becomes 0.
- R7: A write to the set register loads both the set register and the counter, and clears DONE, ERR and `irq_o`.
- R8: A control write replaces RUN, RATE, REPEAT, UP and IE, and clears `irq_o`. If RUN goes from 0 to 1, or RUN stays 1 while RATE changes, the counter reloads from the set register. A rewrite with the same rate while running does not reload.
- R9: A control write with RUN=0 and STEP=1 moves the counter one step in the newly written direction. If that step gives zero, R5 and R6 apply.
- R10: While RUN is 0, and apart from register writes, the counter holds its value.
- R11: `irq_o` is a level that stays high until a register write clears it. Reset clears every register and leaves the clock stopped.
- R12: A tick that arrives in the same cycle as a register write is ignored. The write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_clk_i | input | 1 | Line-frequency input, asynchronous to the system clock |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register index, meaning address bits [2:1] |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the register at `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request level |

## Verification
Writes and tick steps take effect on the clock edge that closes their cycle. Read data follows `addr_i` in the same cycle, and `irq_o` changes on the same edge as the zero that causes it. A rising edge on `line_clk_i` becomes a step three edges later, after the two-flop synchronizer and the edge-detect flop. The bench drives inputs just after the rising edge and samples at the falling edge. Its reference model advances once per rising edge, so every comparison falls in the cycle where the result is due. Scenario checks are placed either right after a write edge, where no tick can intervene, or after a wait long enough for the expected number of ticks to have occurred.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DW    = 16;
  localparam int NRATE = 4;

  localparam int B_RUN  = 0;
  localparam int B_RATE = 1;
  localparam int B_RPT  = 3;
  localparam int B_UP   = 4;
  localparam int B_STEP = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
  localparam int B_ERR  = 15;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic       ie;
    logic       up;
    logic       rpt;
    logic [1:0] rate;
    logic       run;
  } ctl_t;

  function automatic logic [DW-1:0] pack_ctl(ctl_t c, logic done, logic err);
    logic [DW-1:0] v;
    v               = '0;
    v[B_RUN]        = c.run;
    v[B_RATE+:2]    = c.rate;
    v[B_RPT]        = c.rpt;
    v[B_UP]         = c.up;
    v[B_IE]         = c.ie;
    v[B_DONE]       = done;
    v[B_ERR]        = err;
    return v;
  endfunction
endpackage

// File: rtl/itmr_tick_gen.sv
module itmr_tick_gen
  import itmr_pkg::*;
#(
  parameter int CLK_PER_FAST = 2000,
  parameter int FAST_PER_MID = 10,
  parameter int MID_PER_SLOW = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_clk_i,
  output logic [NRATE-1:0] tick_o
);
  localparam int NSTG = 3;

  logic [NSTG-1:0] stb_vec;

  genvar k;
  for (k = 0; k < NSTG; k++) begin : g_stage
    localparam int DIV = (k == 0) ? CLK_PER_FAST : (k == 1) ? FAST_PER_MID : MID_PER_SLOW;
    localparam int W   = $clog2(DIV + 1);
    logic         en;
    logic         stb;
    logic [W-1:0] cnt_q;

    if (k == 0) begin : g_first
      assign en = 1'b1;
    end else begin : g_next
      assign en = g_stage[k-1].stb;
    end

    assign stb        = en && (cnt_q == W'(DIV - 1));
    assign stb_vec[k] = stb;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cnt_q <= '0;
      else if (stb) cnt_q <= '0;
      else if (en)  cnt_q <= cnt_q + 1'b1;
    end
  end

  // two-flop synchronizer plus edge detect
  logic [2:0] line_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= {line_q[1:0], line_clk_i};
  end

  assign tick_o[0] = stb_vec[0];
  assign tick_o[1] = stb_vec[1];
  assign tick_o[2] = line_q[1] & ~line_q[2];
  assign tick_o[3] = stb_vec[2];
endmodule

// File: rtl/itmr_bus_dec.sv
module itmr_bus_dec
  import itmr_pkg::*;
(
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  ctl_t          ctl_i,
  input  logic          done_i,
  input  logic          err_i,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] cnt_i,
  output logic          wr_ctl_o,
  output logic          wr_set_o,
  output logic [DW-1:0] rdata_o
);
  sel_e sel;
  assign sel      = sel_e'(sel_i);
  assign wr_ctl_o = wr_i && (sel == SEL_CTL);
  assign wr_set_o = wr_i && (sel == SEL_SET);

  always_comb begin
    unique case (sel)
      SEL_CTL: rdata_o = pack_ctl(ctl_i, done_i, err_i);
      SEL_SET: rdata_o = set_i;
      SEL_CNT: rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/itmr_core.sv
module itmr_core
  import itmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctl_i,
  input  logic             wr_set_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NRATE-1:0] tick_i,
  output ctl_t             ctl_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    cnt_o,
  output logic [DW-1:0]    set_o,
  output logic             irq_o
);
  ctl_t          ctl_q, ctl_d, w_ctl;
  logic          done_q, done_d, err_q, err_d, irq_q, irq_d;
  logic [DW-1:0] cnt_q, cnt_d, set_q, set_d, nxt;
  logic          step;

  always_comb begin
    w_ctl.run  = wdata_i[B_RUN];
    w_ctl.rate = wdata_i[B_RATE+:2];
    w_ctl.rpt  = wdata_i[B_RPT];
    w_ctl.up   = wdata_i[B_UP];
    w_ctl.ie   = wdata_i[B_IE];
  end

  always_comb begin
    ctl_d  = ctl_q;
    done_d = done_q;
    err_d  = err_q;
    irq_d  = irq_q;
    cnt_d  = cnt_q;
    set_d  = set_q;
    step   = 1'b0;
    if (wr_ctl_i) begin
      ctl_d = w_ctl;
      irq_d = 1'b0;
      if (!w_ctl.run)                                   step  = wdata_i[B_STEP];
      else if (!ctl_q.run || (w_ctl.rate != ctl_q.rate)) cnt_d = set_q;
    end else if (wr_set_i) begin
      set_d  = wdata_i;
      cnt_d  = wdata_i;
      done_d = 1'b0;
      err_d  = 1'b0;
      irq_d  = 1'b0;
    end else if (ctl_q.run && tick_i[ctl_q.rate]) begin
      step = 1'b1;
    end

    nxt = ctl_d.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    if (step) begin
      cnt_d = nxt;
      if (nxt == '0) begin
        if (done_q) err_d  = 1'b1;
        else        done_d = 1'b1;
        if (ctl_d.ie) irq_d = 1'b1;
        if (ctl_d.rpt) begin
          cnt_d = set_q;
        end else begin
          set_d     = '0;
          ctl_d.run = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      cnt_q  <= '0;
      set_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      done_q <= done_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
      cnt_q  <= cnt_d;
      set_q  <= set_d;
    end
  end

  assign ctl_o  = ctl_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign cnt_o  = cnt_q;
  assign set_o  = set_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CLK_PER_FAST = 2000,
  parameter int FAST_PER_MID = 10,
  parameter int MID_PER_SLOW = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_clk_i,
  input  logic          wr_i,
  input  logic [2:1]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [NRATE-1:0] tick;
  logic             wr_ctl, wr_set;
  ctl_t             ctl;
  logic             done, err;
  logic [DW-1:0]    cnt, set;

  itmr_tick_gen #(
    .CLK_PER_FAST(CLK_PER_FAST),
    .FAST_PER_MID(FAST_PER_MID),
    .MID_PER_SLOW(MID_PER_SLOW)
  ) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_clk_i(line_clk_i),
    .tick_o    (tick)
  );

  itmr_bus_dec u_dec (
    .wr_i    (wr_i),
    .sel_i   (addr_i),
    .ctl_i   (ctl),
    .done_i  (done),
    .err_i   (err),
    .set_i   (set),
    .cnt_i   (cnt),
    .wr_ctl_o(wr_ctl),
    .wr_set_o(wr_set),
    .rdata_o (rdata_o)
  );

  itmr_core u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_ctl_i(wr_ctl),
    .wr_set_i(wr_set),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .ctl_o   (ctl),
    .done_o  (done),
    .err_o   (err),
    .cnt_o   (cnt),
    .set_o   (set),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/itmr_checker.sv
module itmr_checker
  import itmr_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [1:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          run,
  input logic          ie,
  input logic          done,
  input logic          err,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] set
);
  AST_SET_WR_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd1) |=> (cnt == $past(wdata_i) && set == $past(wdata_i) && !done && !err && !irq_o)); // R7

  AST_CTL_WR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 2'd0 && !(wdata_i[B_STEP] && !wdata_i[B_RUN])) |=> !irq_o); // R8

  AST_ERR_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err) |-> $past(done)); // R5

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ie); // R5

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !(wr_i && addr_i == 2'd1)) |=> done); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_i) |=> $stable(cnt)); // R10

  AST_STEP_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd0) |-> !rdata_o[B_STEP]); // R2

  AST_IDX3_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 2'd3) |-> (rdata_o == '0)); // R1
endmodule

bind interval_timer itmr_checker u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .run    (ctl.run),
  .ie     (ctl.ie),
  .done   (done),
  .err    (err),
  .cnt    (cnt),
  .set    (set)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  localparam int D0 = 3, D1 = 2, D2 = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  interval_timer #(.CLK_PER_FAST(D0), .FAST_PER_MID(D1), .MID_PER_SLOW(D2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_clk_i(line), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  // reference model state
  int fc, mc, sc;
  bit l1, l2, l3;
  bit m_run, m_rpt, m_up, m_ie, m_done, m_err, m_irq;
  int m_rate;
  int m_cnt, m_set;
  bit t_fast, t_mid, t_slow, t_line, do_step;
  bit [3:0] tk;

  function automatic int m_read(int idx);
    case (idx)
      0: return m_run | (m_rate << 1) | (m_rpt << 3) | (m_up << 4) | (m_ie << 6)
                | (m_done << 7) | (m_err << 15);
      1: return m_set;
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      fc = 0; mc = 0; sc = 0; l1 = 0; l2 = 0; l3 = 0;
      m_run = 0; m_rpt = 0; m_up = 0; m_ie = 0; m_done = 0; m_err = 0; m_irq = 0;
      m_rate = 0; m_cnt = 0; m_set = 0;
    end else begin
      t_fast = (fc == D0 - 1);
      t_mid  = t_fast && (mc == D1 - 1);
      t_slow = t_mid && (sc == D2 - 1);
      t_line = l2 && !l3;
      fc = t_fast ? 0 : fc + 1;
      if (t_fast) mc = t_mid ? 0 : mc + 1;
      if (t_mid)  sc = t_slow ? 0 : sc + 1;
      l3 = l2; l2 = l1; l1 = line;
      tk = {t_slow, t_line, t_mid, t_fast};
      do_step = 0;
      if (wr && addr == 2'd0) begin
        bit old_run; int old_rate;
        old_run = m_run; old_rate = m_rate;
        m_run = wdata[0]; m_rate = wdata[2:1]; m_rpt = wdata[3];
        m_up = wdata[4]; m_ie = wdata[6]; m_irq = 0;
        if (!m_run) do_step = wdata[5];
        else if (!old_run || m_rate != old_rate) m_cnt = m_set;
      end else if (wr && addr == 2'd1) begin
        m_set = wdata; m_cnt = wdata; m_done = 0; m_err = 0; m_irq = 0;
      end else if (!wr && m_run && tk[m_rate]) begin
        do_step = 1;
      end
      if (do_step) begin
        m_cnt = (m_up ? m_cnt + 1 : m_cnt - 1) & 16'hFFFF;
        if (m_cnt == 0) begin
          if (m_done) m_err = 1; else m_done = 1;
          if (m_ie) m_irq = 1;
          if (m_rpt) m_cnt = m_set;
          else begin m_set = 0; m_run = 0; end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (irq !== m_irq) begin
        failures++;
        $display("FAIL R5 irq act=%0b exp=%0b cycle=%0d", irq, m_irq, cyc);
      end
      checks++;
      if (rdata !== 16'(m_read(addr))) begin
        failures++;
        $display("FAIL R1 rdata idx=%0d act=%h exp=%h cycle=%0d", addr, rdata,
                 16'(m_read(addr)), cyc);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wreg(int idx, int data);
    @(posedge clk); #1;
    wr = 1; addr = 2'(idx); wdata = 16'(data);
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic rreg(int idx, output int val);
    addr = 2'(idx);
    @(negedge clk);
    val = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp<=50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, a, b;
    idle(4);
    rst_n = 1;
    idle(1);
    // R11: reset state
    rreg(0, v); chk("R11 ctl reset", v, 0);
    rreg(1, v); chk("R11 set reset", v, 0);
    rreg(2, v); chk("R11 cnt reset", v, 0);
    chk("R11 irq reset", irq, 0);

    // R7: set write loads counter
    wreg(1, 5);
    rreg(2, v); chk("R7 cnt loaded", v, 5);
    rreg(1, v); chk("R7 set loaded", v, 5);

    // R3/R5/R6: fast rate, down, single, IE
    wreg(0, 16'h0041);
    rreg(2, v); chk("R8 run 0->1 reload", v, 5);
    idle(30);
    rreg(0, v); chk("R6 single stops, DONE+IE", v, 16'h00C0);
    rreg(1, v); chk("R6 single clears set", v, 0);
    rreg(2, v); chk("R5 count at zero", v, 0);
    chk("R5 irq raised", irq, 1);
    idle(10);
    chk("R11 irq level held", irq, 1);

    // R2/R8: DONE/ERR not writable, irq cleared
    wreg(0, 16'h8080);
    rreg(0, v); chk("R2 flags read-only", v, 16'h0080);
    chk("R8 ctl write clears irq", irq, 0);

    // R4/R5/R6: medium rate, up, repeat, no IE -> DONE then ERR
    wreg(1, 16'hFFFE);
    rreg(0, v); chk("R7 set write clears DONE", v, 0);
    wreg(0, 16'h001B);
    idle(40);
    rreg(0, v); chk("R5 DONE then ERR, repeat keeps running", v, 16'h809B);
    chk("R5 no irq without IE", irq, 0);
    rreg(1, v); chk("R6 repeat keeps set", v, 16'hFFFE);

    // R10: stop holds
    wreg(0, 16'h0000);
    rreg(2, a);
    idle(20);
    rreg(2, b); chk("R10 stopped counter holds", b, a);

    // R9: manual step down, single
    wreg(1, 2);
    wreg(0, 16'h0060);
    rreg(2, v); chk("R9 step once", v, 1);
    chk("R9 no irq before zero", irq, 0);
    wreg(0, 16'h0060);
    rreg(2, v); chk("R9 step to zero", v, 0);
    rreg(0, v); chk("R9 zero sets DONE, STEP reads 0", v, 16'h00C0);
    chk("R9 zero raises irq", irq, 1);
    rreg(1, v); chk("R9 single clears set", v, 0);

    // R9/R6: manual step in repeat mode reloads
    wreg(1, 1);
    wreg(0, 16'h0028);
    rreg(2, v); chk("R6 step repeat reload", v, 1);
    rreg(0, v); chk("R6 step repeat DONE", v, 16'h0088);

    // R4: down wrap from zero
    wreg(1, 0);
    wreg(0, 16'h0020);
    rreg(2, v); chk("R4 wrap down", v, 16'hFFFF);
    rreg(0, v); chk("R4 wrap not zero", v, 0);

    // R1: writes to index 2 and 3 ignored
    wreg(2, 16'h1234);
    wreg(3, 16'h5555);
    rreg(2, v); chk("R1 cnt write ignored", v, 16'hFFFF);
    rreg(3, v); chk("R1 idx3 reads 0", v, 0);
    rreg(0, v); chk("R1 ctl untouched", v, 0);

    // R3: line rate ignores prescaler ticks, counts line edges
    wreg(1, 3);
    wreg(0, 16'h0005);
    idle(12);
    rreg(2, v); chk("R3 line rate ignores prescalers", v, 3);
    for (int i = 0; i < 3; i++) begin
      line = 1; idle(4);
      line = 0; idle(4);
    end
    idle(4);
    rreg(0, v); chk("R3 line edges reach zero", v, 16'h0084);

    // R3: slow rate
    wreg(1, 1);
    wreg(0, 16'h0007);
    rreg(2, v); chk("R3 slow reload", v, 1);
    idle(30);
    rreg(0, v); chk("R3 slow reaches zero", v, 16'h0086);

    // R8/R12: rate change restarts; same-rate rewrite does not
    wreg(1, 100);
    wreg(0, 16'h0001);
    idle(10);
    wreg(0, 16'h0003);
    rreg(2, v); chk("R8 rate change reloads", v, 100);
    idle(14);
    wreg(0, 16'h0003);
    rreg(2, v); chk("R8 same rate no reload", v < 100, 1);
    wreg(0, 16'h0000);
    idle(5);

    // R11: reset mid-state
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    rreg(0, v); chk("R11 reset clears ctl", v, 0);
    rreg(2, v); chk("R11 reset clears cnt", v, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule